// File: doc/BRIEF.md
# Issue-Stage Register Hazard Stall Calculator

This block sits at the issue point of an in-order pipeline and decides how long each instruction must wait before it may start. It keeps a small scoreboard with one entry per general register plus one extra entry for the condition flags. The flag groups are tracked together as a single item. Each entry holds how many cycles remain until the newest pending result in it can be forwarded. It also holds one bit that records whether that result came from a multiply.

Instructions arrive already decoded, one per accepted handshake. Each descriptor lists up to three register sources and a flags source, each with the pipeline stage at which the value is first needed. It lists up to two register destinations and a flags destination, each with the stage at which the value is produced. It also gives the instruction's cycle count, whether it is conditional, whether it is a multiply, and whether its last source slot is an accumulator. Source stages count from the instruction's first cycle and result stages from its last cycle. The block returns the stall count one cycle after acceptance. It then holds off the next descriptor for the stall plus the remaining cycles of the instruction, and it records the new results in the table. The answer never depends on data values: it is a static schedule.

Top module: `hz_stall_calc`

## Requirements
- R1: After a synchronous active-high reset, in_ready is 1, res_valid is 0, and every register and the flags read as ready, so the first descriptor gets a stall of 0.
- R2: A producer that issues (after its own stall) in cycle P, with cycle count c and result stage e, lets a consumer that needs stage q and is first offered for issue in cycle T issue after max(0, P + c + e − q − T) stall cycles. Over all enabled sources the largest such value is taken, and stale entries never stall.
- R3: res_valid pulses for one cycle in the cycle after an accepted descriptor, carrying res_stall. in_ready then stays low so that the next descriptor is accepted no earlier than s + c cycles after this one, where s is the stall and c is the cycle count, with a count of 0 treated as 1.
- R4: The flags are one scoreboard item, written through flg_dst_en/flg_dst_stg and read through flg_src_en/flg_src_stg. A pending flags result delays only descriptors that read the flags, and pending register results do not delay a flags-only reader.
- R5: carry_in = 1 makes the flags a source at stage flg_src_stg even when flg_src_en = 0.
- R6: When cond = 1, a destination result stage of 1 is treated as 2. Other stages are unchanged.
- R7: When acc_en = 1 and the register in source slot 2 was last written by a descriptor with is_mul = 1, that source is needed at stage ACC_LATE (default 5) instead of its given stage. Slots 0 and 1 are never adjusted.
- R8: Register 15 (the program counter) is always needed at stage 1 and produced at stage 1, whatever stage the descriptor gives.
- R9: A pending distance that exceeds 2^CNT_W − 1 cycles is clamped to 2^CNT_W − 1 when written.
- R10: When both destination slots name the same register, slot 1's result is the one recorded.
- R11: A source slot whose src_en bit is 0 causes no stall, and a destination slot whose dst_en bit is 0 writes nothing to the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Block can accept a descriptor this cycle |
| src_en | input | NSRC | Enable per register source slot |
| src_reg | input | NSRC*log2(NREG) | Register index per source slot, slot i at [i*4 +: 4] by default |
| src_stg | input | NSRC*STG_W | Needed stage per source slot |
| acc_en | input | 1 | Source slot NSRC−1 is a multiply accumulator |
| flg_src_en | input | 1 | Flags are a source |
| flg_src_stg | input | STG_W | Stage at which the flags are needed |
| carry_in | input | 1 | Instruction consumes carry; forces flags as source |
| dst_en | input | NDST | Enable per register destination slot |
| dst_reg | input | NDST*log2(NREG) | Register index per destination slot |
| dst_stg | input | NDST*STG_W | Result stage per destination slot |
| flg_dst_en | input | 1 | Flags are a destination |
| flg_dst_stg | input | STG_W | Result stage of the flags |
| cycles | input | CYC_W | Issue cycle count of the instruction |
| cond | input | 1 | Instruction is conditional |
| is_mul | input | 1 | Instruction is a multiply |
| res_valid | output | 1 | Stall result valid |
| res_stall | output | CNT_W | Stall cycles before issue |

## Verification
The bench builds the block with CNT_W = 4 and the other parameters at their defaults. A 15-cycle instruction with a stage-7 result then overflows the four-bit distance, so the clamp of R9 is exercised directly. The default register count places the program counter at index 15, and the default ACC_LATE of 5 checks the late accumulator rule against an ordinary stage-3 read. The bench model keeps absolute ready times rather than countdowns. It checks each stall and also the exact cycle at which the next descriptor is accepted.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Effective stage at which a source is needed.
  function automatic int unsigned f_src_stage(input int unsigned idx,
                                              input int unsigned stg,
                                              input bit acc,
                                              input bit mul_prod,
                                              input int unsigned late,
                                              input int unsigned pc_idx);
    if (idx == pc_idx) return 1;
    if (acc && mul_prod) return late;
    return stg;
  endfunction

  // Effective stage at which a register destination is produced.
  function automatic int unsigned f_dst_stage(input int unsigned idx,
                                              input int unsigned stg,
                                              input bit cond,
                                              input int unsigned pc_idx);
    if (idx == pc_idx) return 1;
    if (cond && stg == 1) return 2;
    return stg;
  endfunction

  // Cycles of wait caused by a pending distance against a needed stage.
  function automatic int unsigned f_need(input int unsigned pend,
                                         input int unsigned stg);
    return (pend > stg) ? pend - stg : 0;
  endfunction

  function automatic int unsigned f_clamp(input int unsigned v,
                                          input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  // Pending distance written for a result: stall + cycles + stage - 1.
  function automatic int unsigned f_dist(input int unsigned stall,
                                         input int unsigned cyc,
                                         input int unsigned stg);
    return stall + cyc + stg - 1;
  endfunction

endpackage

// File: rtl/hz_src_lane.sv
module hz_src_lane
  import hz_pkg::*;
#(
  parameter int unsigned NENT     = 17,
  parameter int unsigned ENT_W    = 5,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned STG_W    = 3,
  parameter int unsigned PC_IDX   = 15,
  parameter int unsigned ACC_LATE = 5
) (
  input  logic                  en,
  input  logic [ENT_W-1:0]      idx,
  input  logic [STG_W-1:0]      stg,
  input  logic                  acc,
  input  logic [NENT*CNT_W-1:0] cnt_flat,
  input  logic [NENT-1:0]       mul_flat,
  output logic [CNT_W-1:0]      need
);

  logic [CNT_W-1:0] pend;
  logic             mulp;
  int unsigned      eff_stg;

  always_comb begin
    pend = '0;
    mulp = 1'b0;
    for (int i = 0; i < int'(NENT); i++) begin
      if (idx == ENT_W'(i)) begin
        pend = cnt_flat[i*CNT_W +: CNT_W];
        mulp = mul_flat[i];
      end
    end
  end

  always_comb begin
    eff_stg = f_src_stage(32'(idx), 32'(stg), acc, mulp, ACC_LATE, PC_IDX);
    need    = en ? CNT_W'(f_need(32'(pend), eff_stg)) : '0;
  end

endmodule

// File: rtl/hz_table.sv
module hz_table
  import hz_pkg::*;
#(
  parameter int unsigned NENT    = 17,
  parameter int unsigned NDST    = 2,
  parameter int unsigned RIDX_W  = 4,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned STG_W   = 3,
  parameter int unsigned CYC_W   = 4,
  parameter int unsigned PC_IDX  = 15,
  parameter int unsigned FLG_IDX = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [NDST-1:0]        dst_en,
  input  logic [NDST*RIDX_W-1:0] dst_reg,
  input  logic [NDST*STG_W-1:0]  dst_stg,
  input  logic                   fdst_en,
  input  logic [STG_W-1:0]       fdst_stg,
  input  logic                   cond,
  input  logic                   is_mul,
  input  logic [CNT_W-1:0]       stall,
  input  logic [CYC_W-1:0]       cyc_eff,
  output logic [NENT*CNT_W-1:0]  cnt_flat,
  output logic [NENT-1:0]        mul_flat
);

  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] wval [NDST];
  logic [CNT_W-1:0] wflg;

  always_comb begin
    for (int k = 0; k < int'(NDST); k++) begin
      wval[k] = CNT_W'(f_clamp(
                  f_dist(32'(stall), 32'(cyc_eff),
                         f_dst_stage(32'(dst_reg[k*RIDX_W +: RIDX_W]),
                                     32'(dst_stg[k*STG_W +: STG_W]),
                                     cond, PC_IDX)),
                  CMAX));
    end
    wflg = CNT_W'(f_clamp(f_dist(32'(stall), 32'(cyc_eff), 32'(fdst_stg)), CMAX));
  end

  for (genvar g = 0; g < int'(NENT); g++) begin : g_ent
    logic [CNT_W-1:0] cnt_q;
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;

    if (g == int'(FLG_IDX)) begin : g_flg
      always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (wr && fdst_en)  cnt_q <= wflg;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign mul_flat[g] = 1'b0;
    end else begin : g_reg
      logic             hit;
      logic [CNT_W-1:0] hval;
      logic             mul_q;

      // Later slot overrides earlier one on the same register.
      always_comb begin
        hit  = 1'b0;
        hval = '0;
        for (int k = 0; k < int'(NDST); k++) begin
          if (dst_en[k] && dst_reg[k*RIDX_W +: RIDX_W] == RIDX_W'(g)) begin
            hit  = 1'b1;
            hval = wval[k];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          mul_q <= 1'b0;
        end else if (wr && hit) begin
          cnt_q <= hval;
          mul_q <= is_mul;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      assign mul_flat[g] = mul_q;
    end
  end

endmodule

// File: rtl/hz_issue_ctl.sv
module hz_issue_ctl #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CYC_W = 4,
  parameter int unsigned SUM_W = CNT_W + CYC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] stall,
  input  logic [CYC_W-1:0] cyc_eff,
  output logic             in_ready,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_stall
);

  logic [SUM_W-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= '0;
      res_valid <= 1'b0;
      res_stall <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_stall <= stall;
        busy_q    <= SUM_W'(stall) + SUM_W'(cyc_eff) - SUM_W'(1);
      end else if (busy_q != '0) begin
        busy_q <= busy_q - SUM_W'(1);
      end
    end
  end

  assign in_ready = (busy_q == '0);

endmodule

// File: rtl/hz_stall_calc.sv
module hz_stall_calc
  import hz_pkg::*;
#(
  parameter int unsigned NREG     = 16,
  parameter int unsigned NSRC     = 3,
  parameter int unsigned NDST     = 2,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned STG_W    = 3,
  parameter int unsigned CYC_W    = 4,
  parameter int unsigned ACC_LATE = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [NSRC-1:0]                 src_en,
  input  logic [NSRC*$clog2(NREG)-1:0]    src_reg,
  input  logic [NSRC*STG_W-1:0]           src_stg,
  input  logic                            acc_en,
  input  logic                            flg_src_en,
  input  logic [STG_W-1:0]                flg_src_stg,
  input  logic                            carry_in,
  input  logic [NDST-1:0]                 dst_en,
  input  logic [NDST*$clog2(NREG)-1:0]    dst_reg,
  input  logic [NDST*STG_W-1:0]           dst_stg,
  input  logic                            flg_dst_en,
  input  logic [STG_W-1:0]                flg_dst_stg,
  input  logic [CYC_W-1:0]                cycles,
  input  logic                            cond,
  input  logic                            is_mul,
  output logic                            res_valid,
  output logic [CNT_W-1:0]                res_stall
);

  localparam int unsigned NENT     = NREG + 1;
  localparam int unsigned RIDX_W   = $clog2(NREG);
  localparam int unsigned ENT_W    = $clog2(NENT);
  localparam int unsigned PC_IDX   = NREG - 1;
  localparam int unsigned FLG_IDX  = NREG;
  localparam int unsigned NLANE    = NSRC + 1;
  localparam int unsigned ACC_SLOT = NSRC - 1;
  localparam int unsigned SUM_W    = CNT_W + CYC_W + 1;

  logic                  fire;
  logic [NENT*CNT_W-1:0] cnt_flat;
  logic [NENT-1:0]       mul_flat;
  logic [NLANE*CNT_W-1:0] need_flat;
  logic [CNT_W-1:0]      stall_w;
  logic [CYC_W-1:0]      cyc_eff;
  logic                  pc_wr;
  logic [CNT_W-1:0]      pc_cnt;

  assign fire    = in_valid && in_ready;
  assign cyc_eff = (cycles == '0) ? CYC_W'(1) : cycles;
  assign pc_cnt  = cnt_flat[PC_IDX*CNT_W +: CNT_W];

  for (genvar g = 0; g < int'(NSRC); g++) begin : g_src
    hz_src_lane #(
      .NENT(NENT), .ENT_W(ENT_W), .CNT_W(CNT_W), .STG_W(STG_W),
      .PC_IDX(PC_IDX), .ACC_LATE(ACC_LATE)
    ) u_lane (
      .en      (src_en[g]),
      .idx     (ENT_W'(src_reg[g*RIDX_W +: RIDX_W])),
      .stg     (src_stg[g*STG_W +: STG_W]),
      .acc     ((g == int'(ACC_SLOT)) && acc_en),
      .cnt_flat(cnt_flat),
      .mul_flat(mul_flat),
      .need    (need_flat[g*CNT_W +: CNT_W])
    );
  end

  hz_src_lane #(
    .NENT(NENT), .ENT_W(ENT_W), .CNT_W(CNT_W), .STG_W(STG_W),
    .PC_IDX(PC_IDX), .ACC_LATE(ACC_LATE)
  ) u_flg_lane (
    .en      (flg_src_en || carry_in),
    .idx     (ENT_W'(FLG_IDX)),
    .stg     (flg_src_stg),
    .acc     (1'b0),
    .cnt_flat(cnt_flat),
    .mul_flat(mul_flat),
    .need    (need_flat[NSRC*CNT_W +: CNT_W])
  );

  always_comb begin
    stall_w = '0;
    for (int i = 0; i < int'(NLANE); i++) begin
      if (need_flat[i*CNT_W +: CNT_W] > stall_w) stall_w = need_flat[i*CNT_W +: CNT_W];
    end
  end

  always_comb begin
    pc_wr = 1'b0;
    for (int k = 0; k < int'(NDST); k++) begin
      if (fire && dst_en[k] && dst_reg[k*RIDX_W +: RIDX_W] == RIDX_W'(PC_IDX)) pc_wr = 1'b1;
    end
  end

  hz_table #(
    .NENT(NENT), .NDST(NDST), .RIDX_W(RIDX_W), .CNT_W(CNT_W), .STG_W(STG_W),
    .CYC_W(CYC_W), .PC_IDX(PC_IDX), .FLG_IDX(FLG_IDX)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr      (fire),
    .dst_en  (dst_en),
    .dst_reg (dst_reg),
    .dst_stg (dst_stg),
    .fdst_en (flg_dst_en),
    .fdst_stg(flg_dst_stg),
    .cond    (cond),
    .is_mul  (is_mul),
    .stall   (stall_w),
    .cyc_eff (cyc_eff),
    .cnt_flat(cnt_flat),
    .mul_flat(mul_flat)
  );

  hz_issue_ctl #(.CNT_W(CNT_W), .CYC_W(CYC_W), .SUM_W(SUM_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .stall    (stall_w),
    .cyc_eff  (cyc_eff),
    .in_ready (in_ready),
    .res_valid(res_valid),
    .res_stall(res_stall)
  );

endmodule

// File: rtl/hz_stall_calc_chk.sv
module hz_stall_calc_chk #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CYC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             res_valid,
  input logic             fire,
  input logic [CNT_W-1:0] stall_w,
  input logic [CYC_W-1:0] cyc_eff,
  input logic             pc_wr,
  input logic [CNT_W-1:0] pc_cnt
);

  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  p_result_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> res_valid);

  p_result_needs_accept_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_ready));

  p_hold_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && (stall_w != '0 || cyc_eff > CYC_W'(1))) |=> !in_ready);

  p_free_after_single_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && stall_w == '0 && cyc_eff == CYC_W'(1)) |=> in_ready);

  p_pc_stage_one_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && (32'(stall_w) + 32'(cyc_eff) <= CMAX))
      |=> 32'(pc_cnt) == $past(32'(stall_w) + 32'(cyc_eff)));

  p_pending_decays_r2: assert property (@(posedge clk) disable iff (rst)
    (!fire && pc_cnt != '0) |=> pc_cnt == $past(pc_cnt) - 1'b1);

endmodule

bind hz_stall_calc hz_stall_calc_chk #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .res_valid(res_valid),
  .fire     (fire),
  .stall_w  (stall_w),
  .cyc_eff  (cyc_eff),
  .pc_wr    (pc_wr),
  .pc_cnt   (pc_cnt)
);

// File: tb/sim_hz_stall_calc.sv
module sim_hz_stall_calc;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 4;
  localparam int CMAX = 15;
  localparam int FI   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] src_en = '0;
  logic [11:0] src_reg = '0;
  logic [8:0] src_stg = '0;
  logic acc_en = 1'b0, flg_src_en = 1'b0, carry_in = 1'b0;
  logic [2:0] flg_src_stg = '0;
  logic [1:0] dst_en = '0;
  logic [7:0] dst_reg = '0;
  logic [5:0] dst_stg = '0;
  logic flg_dst_en = 1'b0;
  logic [2:0] flg_dst_stg = '0;
  logic [3:0] cycles = '0;
  logic cond = 1'b0, is_mul = 1'b0;
  logic res_valid;
  logic [CW-1:0] res_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_stall_calc #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_en(src_en), .src_reg(src_reg), .src_stg(src_stg), .acc_en(acc_en),
    .flg_src_en(flg_src_en), .flg_src_stg(flg_src_stg), .carry_in(carry_in),
    .dst_en(dst_en), .dst_reg(dst_reg), .dst_stg(dst_stg),
    .flg_dst_en(flg_dst_en), .flg_dst_stg(flg_dst_stg), .cycles(cycles),
    .cond(cond), .is_mul(is_mul), .res_valid(res_valid), .res_stall(res_stall)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int ready_at [0:16];
  bit mul_by [0:16];
  int free_at = 0;
  int exp_q[$];
  string tag_q[$];

  // descriptor under construction
  bit b_sen[3]; int b_sreg[3]; int b_sstg[3]; bit b_acc; bit b_fse; int b_fss; bit b_carry;
  bit b_den[2]; int b_dreg[2]; int b_dstg[2]; bit b_fde; int b_fds; int b_cyc; bit b_cond; bit b_mul;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 3; i++) begin b_sen[i] = 0; b_sreg[i] = 0; b_sstg[i] = 0; end
    for (int i = 0; i < 2; i++) begin b_den[i] = 0; b_dreg[i] = 0; b_dstg[i] = 0; end
    b_acc = 0; b_fse = 0; b_fss = 0; b_carry = 0; b_fde = 0; b_fds = 0;
    b_cyc = 1; b_cond = 0; b_mul = 0;
  endtask

  function automatic int lim(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Presents one descriptor, predicts its stall, then releases in_valid.
  task automatic go(input string tag);
    int t, tp, s, q, w, c, e, want_t;
    for (int i = 0; i < 3; i++) begin
      src_en[i] = b_sen[i];
      src_reg[i*4 +: 4] = 4'(b_sreg[i]);
      src_stg[i*3 +: 3] = 3'(b_sstg[i]);
    end
    for (int i = 0; i < 2; i++) begin
      dst_en[i] = b_den[i];
      dst_reg[i*4 +: 4] = 4'(b_dreg[i]);
      dst_stg[i*3 +: 3] = 3'(b_dstg[i]);
    end
    acc_en = b_acc; flg_src_en = b_fse; flg_src_stg = 3'(b_fss); carry_in = b_carry;
    flg_dst_en = b_fde; flg_dst_stg = 3'(b_fds); cycles = 4'(b_cyc);
    cond = b_cond; is_mul = b_mul;
    in_valid = 1'b1;
    tp = cyc;
    while (!in_ready) @(negedge clk);
    t = cyc;
    s = 0;
    for (int i = 0; i < 3; i++) begin
      if (b_sen[i]) begin
        if (b_sreg[i] == 15) q = 1;
        else if (i == 2 && b_acc && mul_by[b_sreg[i]]) q = 5;
        else q = b_sstg[i];
        w = ready_at[b_sreg[i]] - q - t;
        if (w > s) s = w;
      end
    end
    if (b_fse || b_carry) begin
      w = ready_at[FI] - b_fss - t;
      if (w > s) s = w;
    end
    c = (b_cyc == 0) ? 1 : b_cyc;
    want_t = (tp > free_at) ? tp : free_at;
    chk(t == want_t, {"R3 accept cycle ", tag}, t, want_t);
    free_at = t + s + c;
    for (int k = 0; k < 2; k++) begin
      if (b_den[k]) begin
        if (b_dreg[k] == 15) e = 1;
        else if (b_cond && b_dstg[k] == 1) e = 2;
        else e = b_dstg[k];
        ready_at[b_dreg[k]] = lim(t + s + c + e, t + 1 + CMAX);
        mul_by[b_dreg[k]] = b_mul;
      end
    end
    if (b_fde) ready_at[FI] = lim(t + s + c + b_fds, t + 1 + CMAX);
    exp_q.push_back(s);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected result", int'(res_stall), -1);
      end else begin
        int ev;
        string tg;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(int'(res_stall) == ev, tg, int'(res_stall), ev);
      end
    end
  end

  initial begin
    for (int i = 0; i <= 16; i++) begin ready_at[i] = 0; mul_by[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    free_at = cyc;

    // R1: fresh table
    clr(); b_sen = '{1,1,1}; b_sreg = '{1,2,3}; b_sstg = '{0,0,0}; b_fse = 1; b_fss = 0;
    go("R1 fresh table no stall");

    // R2: basic forwarding
    clr(); b_den[0] = 1; b_dreg[0] = 1; b_dstg[0] = 2; go("R2 producer alu");
    clr(); b_sen[0] = 1; b_sreg[0] = 1; b_sstg[0] = 2; go("R2 alu to alu no stall");
    clr(); b_den[0] = 1; b_dreg[0] = 2; b_dstg[0] = 3; go("R2 producer load");
    clr(); b_sen[0] = 1; b_sreg[0] = 2; b_sstg[0] = 2; go("R2 load-use one stall");
    clr(); b_den = '{1,1}; b_dreg = '{3,4}; b_dstg = '{5,3}; b_cyc = 2; go("R2 two results");
    clr(); b_sen = '{1,1,0}; b_sreg = '{4,3,0}; b_sstg = '{2,1,0}; go("R2 max over sources");

    // R4: flags as a single item
    clr(); b_fde = 1; b_fds = 4; go("R4 flag producer");
    clr(); b_sen[0] = 1; b_sreg[0] = 0; b_sstg[0] = 1; go("R4 register read ignores flags");
    clr(); b_fse = 1; b_fss = 1; go("R4 flag read waits");
    clr(); b_den[0] = 1; b_dreg[0] = 5; b_dstg[0] = 7; go("R4 register producer");
    clr(); b_fse = 1; b_fss = 0; go("R4 flags-only read ignores registers");

    // R5: carry forces flags source
    clr(); b_fde = 1; b_fds = 3; go("R5 flag producer");
    clr(); b_carry = 1; b_fss = 1; go("R5 carry reads flags");
    clr(); b_fde = 1; b_fds = 3; go("R5 flag producer again");
    clr(); b_fss = 1; go("R5 no carry no flag read");

    // R6: conditional late result
    clr(); b_den[0] = 1; b_dreg[0] = 6; b_dstg[0] = 1; go("R6 unconditional move");
    clr(); b_sen[0] = 1; b_sreg[0] = 6; b_sstg[0] = 1; go("R6 after unconditional");
    clr(); b_den[0] = 1; b_dreg[0] = 6; b_dstg[0] = 1; b_cond = 1; go("R6 conditional move");
    clr(); b_sen[0] = 1; b_sreg[0] = 6; b_sstg[0] = 1; go("R6 after conditional");

    // R7: accumulator fed by multiply
    clr(); b_den[0] = 1; b_dreg[0] = 7; b_dstg[0] = 5; b_cyc = 2; b_mul = 1; go("R7 multiply producer");
    clr(); b_sen[2] = 1; b_sreg[2] = 7; b_sstg[2] = 3; b_acc = 1; go("R7 accumulate from multiply");
    clr(); b_den[0] = 1; b_dreg[0] = 7; b_dstg[0] = 5; b_cyc = 2; go("R7 plain producer");
    clr(); b_sen[2] = 1; b_sreg[2] = 7; b_sstg[2] = 3; b_acc = 1; go("R7 accumulate from plain");
    clr(); b_den[0] = 1; b_dreg[0] = 7; b_dstg[0] = 5; b_cyc = 2; b_mul = 1; go("R7 multiply producer again");
    clr(); b_sen[0] = 1; b_sreg[0] = 7; b_sstg[0] = 3; b_acc = 1; go("R7 slot 0 not adjusted");

    // R8: program counter fixed stage
    clr(); b_den[0] = 1; b_dreg[0] = 15; b_dstg[0] = 6; go("R8 pc producer");
    clr(); b_sen[0] = 1; b_sreg[0] = 15; b_sstg[0] = 6; go("R8 pc consumer");
    clr(); b_den[0] = 1; b_dreg[0] = 15; b_dstg[0] = 7; b_cyc = 3; go("R8 pc multi-cycle producer");
    clr(); b_sen[0] = 1; b_sreg[0] = 15; b_sstg[0] = 0; go("R8 pc needed at one");

    // R9: clamp
    clr(); b_den[0] = 1; b_dreg[0] = 9; b_dstg[0] = 7; b_cyc = 15; go("R9 long producer");
    clr(); b_sen[0] = 1; b_sreg[0] = 9; b_sstg[0] = 0; go("R9 clamped distance");

    // R10: same register in both destination slots
    clr(); b_den = '{1,1}; b_dreg = '{10,10}; b_dstg = '{7,1}; go("R10 double write");
    clr(); b_sen[0] = 1; b_sreg[0] = 10; b_sstg[0] = 1; go("R10 slot one wins");

    // R11: disabled slots
    clr(); b_dreg[0] = 11; b_dstg[0] = 7; go("R11 disabled destination");
    clr(); b_sen[0] = 1; b_sreg[0] = 11; b_sstg[0] = 0; go("R11 no write seen");
    clr(); b_den[0] = 1; b_dreg[0] = 11; b_dstg[0] = 7; go("R11 real producer");
    clr(); b_sen = '{0,1,0}; b_sreg = '{11,12,0}; b_sstg = '{0,0,0}; go("R11 disabled source");
    clr(); b_sen[0] = 1; b_sreg[0] = 11; b_sstg[0] = 0; go("R11 enabled source waits");

    // R2: stale entry after idle, R3: zero cycle count
    clr(); b_den[0] = 1; b_dreg[0] = 13; b_dstg[0] = 7; b_cyc = 0; go("R3 zero cycle count");
    repeat (12) @(negedge clk);
    clr(); b_sen[0] = 1; b_sreg[0] = 13; b_sstg[0] = 0; go("R2 stale entry ready");
    clr(); b_cyc = 4; go("R3 four-cycle hold");
    clr(); go("R3 after hold");

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all results returned", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule